// File: doc/BRIEF.md
# DMA Bus Request and Address Strobe Sequencer

This block handles the bus side of a four-channel DMA controller. A channel wants service when its request input is high and its mask bit is clear, or when its software request bit is set. The block then asks for the system bus with a hold request and waits in a wait state for the hold acknowledge. With the bus granted it turns on address enable, drives the acknowledge line of the granted channel and puts the current address on its outputs. The low address byte goes out directly. The high byte goes out on a separate port, together with an active-high strobe that loads an external transparent latch.

Every service starts with one strobe state, so the external latch always holds a valid high byte. In single mode a service is one transfer long. In block mode transfers follow back to back until the end-of-process input is pulled low during a transfer. The address advances by one per transfer, and a strobe state is inserted only when that increment carries into the high byte. The acknowledge lines can be set to active high or active low; reset selects active low. The start address of the granted channel is taken from the `startAddr` input at the moment the channel is granted.

Top module: `dmaBusSeq`

## Requirements
- R1: A channel is pending when chanReq[i] is 1 and chanMask[i] is 0, or when softReq[i] is 1. While idle, holdReq rises in the cycle after a pending channel appears. A request whose mask bit is set and whose software bit is clear leaves holdReq at 0.
- R2: After holdReq rises, the block stays in the wait state until holdAck is 1. During that state addrEn is 0 and the acknowledge lines are inactive. If holdAck answers in the same cycle, the wait state lasts exactly one cycle.
- R3: When several channels are pending at once, the lowest-numbered channel is granted. Channel 0 has the highest priority and channel 3 the lowest. Bit i of chanAck belongs to channel i.
- R4: The first bus cycle of every service is a strobe state. In that state addrEn is 1, upperStb is 1 and upperOut holds bits 15:8 of the start address.
- R5: In block mode a transfer that keeps the same high byte follows the previous transfer with no strobe state. When the low byte wraps from 0xFF to 0x00, exactly one strobe state carrying the new high byte comes before the next transfer.
- R6: The first transfer uses startAddr. Each later transfer in block mode uses the previous address plus one, and addrOut shows bits 7:0 of that address. addrOut is 0 while addrEn is 0.
- R7: A single-mode service (blockMode 0) ends after one transfer. A block-mode service ends with the transfer during which eopN is 0. In the cycle after the last transfer, holdReq and addrEn are both 0.
- R8: After reset the acknowledge lines are active low: all ones when idle, with a 0 on the granted bit. A cycle with polWr at 1 stores polHigh. When polHigh is 1, the lines are all zeros when idle, with a 1 on the granted bit.
- R9: addrEn is 1 only in strobe and transfer states. While addrEn is 1, exactly one acknowledge line is at its active level. While addrEn is 0, none is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; state changes on the rising edge, the high-byte strobe on the falling edge |
| rstN | input | 1 | Asynchronous active-low reset |
| chanReq | input | 4 | Peripheral request per channel |
| chanMask | input | 4 | Mask bit per channel; 1 blocks chanReq |
| softReq | input | 4 | Software request per channel; ignores the mask |
| blockMode | input | 1 | 1 = block transfers, 0 = single transfer |
| eopN | input | 1 | Active-low end of process, sampled during transfers |
| startAddr | input | 16 | Start address of the channel being granted |
| polWr | input | 1 | Write strobe for the acknowledge polarity |
| polHigh | input | 1 | Polarity value written by polWr; 1 = active high |
| holdAck | input | 1 | Bus grant from the system |
| holdReq | output | 1 | Bus request |
| addrEn | output | 1 | Active-high address enable while the block owns the bus |
| chanAck | output | 4 | Per-channel acknowledge, with the programmed polarity |
| addrOut | output | 8 | Low address byte, driven while addrEn is 1 |
| upperOut | output | 8 | High address byte for the external latch |
| upperStb | output | 1 | Active-high load strobe for the high-byte latch |

## Verification
Most wrong states in the sequencer show up at the ports within one clock. A wrong next state either adds a strobe cycle or drops one, and that shifts every later address by one cycle. A lost grant register shows up as a wrong or doubled acknowledge bit in the first strobe state. Address counter errors show up on addrOut at the next transfer, and on upperOut at the next low-byte wrap. A bad ending keeps addrEn or holdReq high one cycle too long. The bench compares every port in every cycle of each service, so these errors are caught in the cycle where they first appear.

// File: rtl/dmaSeqPkg.sv
package dmaSeqPkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_WAIT   = 2'd1,
    ST_STROBE = 2'd2,
    ST_XFER   = 2'd3
  } seqState_t;

  typedef struct packed {
    logic load;     // capture start address and grant
    logic advance;  // step address to next transfer
    logic busOwn;   // bus owned: drive address and acknowledge
    logic strobe;   // high-byte strobe state
  } pathCtl_t;
endpackage

// File: rtl/dmaSeqCtrl.sv
module dmaSeqCtrl
  import dmaSeqPkg::*;
#(
  parameter int NUM_CH = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [NUM_CH-1:0] chanReq,
  input  logic [NUM_CH-1:0] chanMask,
  input  logic [NUM_CH-1:0] softReq,
  input  logic              blockMode,
  input  logic              eopN,
  input  logic              holdAck,
  input  logic              upperWrap,
  output pathCtl_t          ctl,
  output logic [NUM_CH-1:0] grantOh,
  output logic              holdReq
);
  localparam logic [NUM_CH-1:0] ONE = {{(NUM_CH-1){1'b0}}, 1'b1};

  seqState_t state, nextState;
  logic [NUM_CH-1:0] pending;
  logic [NUM_CH-1:0] prioOh;
  logic              lastXfer;

  assign pending  = (chanReq & ~chanMask) | softReq;
  assign lastXfer = !blockMode || !eopN;

  // fixed priority: lowest index wins
  always_comb begin
    prioOh = '0;
    for (int i = NUM_CH - 1; i >= 0; i--) begin
      if (pending[i]) prioOh = ONE << i;
    end
  end

  always_comb begin
    nextState   = state;
    ctl.load    = 1'b0;
    ctl.advance = 1'b0;
    case (state)
      ST_IDLE: begin
        if (|pending) begin
          nextState = ST_WAIT;
          ctl.load  = 1'b1;
        end
      end
      ST_WAIT:   if (holdAck) nextState = ST_STROBE;
      ST_STROBE: nextState = ST_XFER;
      ST_XFER: begin
        if (lastXfer) begin
          nextState = ST_IDLE;
        end else begin
          ctl.advance = 1'b1;
          nextState   = upperWrap ? ST_STROBE : ST_XFER;
        end
      end
      default:   nextState = ST_IDLE;
    endcase
  end

  assign ctl.busOwn = (state == ST_STROBE) || (state == ST_XFER);
  assign ctl.strobe = (state == ST_STROBE);
  assign holdReq    = (state != ST_IDLE);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      grantOh <= '0;
    end else begin
      state <= nextState;
      if (ctl.load) grantOh <= prioOh;
    end
  end
endmodule

// File: rtl/dmaSeqPath.sv
module dmaSeqPath
  import dmaSeqPkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int ADDR_W = 16,
  parameter int LOW_W  = 8
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  pathCtl_t                ctl,
  input  logic [NUM_CH-1:0]       grantOh,
  input  logic [ADDR_W-1:0]       startAddr,
  input  logic                    polWr,
  input  logic                    polHigh,
  output logic [NUM_CH-1:0]       chanAck,
  output logic [LOW_W-1:0]        addrOut,
  output logic [ADDR_W-LOW_W-1:0] upperOut,
  output logic                    upperStb,
  output logic                    upperWrap
);
  logic [ADDR_W-1:0] curAddr;
  logic              ackHigh;
  logic [NUM_CH-1:0] ackRaw;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curAddr <= '0;
      ackHigh <= 1'b0;
    end else begin
      if (ctl.load)         curAddr <= startAddr;
      else if (ctl.advance) curAddr <= curAddr + 1'b1;
      if (polWr)            ackHigh <= polHigh;
    end
  end

  // high-byte strobe launched from the falling edge
  always_ff @(negedge clk or negedge rstN) begin
    if (!rstN) upperStb <= 1'b0;
    else       upperStb <= ctl.strobe;
  end

  assign upperWrap = &curAddr[LOW_W-1:0];
  assign ackRaw    = ctl.busOwn ? grantOh : '0;
  assign chanAck   = ackHigh ? ackRaw : ~ackRaw;
  assign addrOut   = ctl.busOwn ? curAddr[LOW_W-1:0] : '0;
  assign upperOut  = curAddr[ADDR_W-1:LOW_W];
endmodule

// File: rtl/dmaBusSeq.sv
module dmaBusSeq
  import dmaSeqPkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int ADDR_W = 16,
  parameter int LOW_W  = 8
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic [NUM_CH-1:0]       chanReq,
  input  logic [NUM_CH-1:0]       chanMask,
  input  logic [NUM_CH-1:0]       softReq,
  input  logic                    blockMode,
  input  logic                    eopN,
  input  logic [ADDR_W-1:0]       startAddr,
  input  logic                    polWr,
  input  logic                    polHigh,
  input  logic                    holdAck,
  output logic                    holdReq,
  output logic                    addrEn,
  output logic [NUM_CH-1:0]       chanAck,
  output logic [LOW_W-1:0]        addrOut,
  output logic [ADDR_W-LOW_W-1:0] upperOut,
  output logic                    upperStb
);
  pathCtl_t          ctl;
  logic [NUM_CH-1:0] grantOh;
  logic              upperWrap;

  dmaSeqCtrl #(.NUM_CH(NUM_CH)) uCtrl (
    .clk(clk), .rstN(rstN), .chanReq(chanReq), .chanMask(chanMask),
    .softReq(softReq), .blockMode(blockMode), .eopN(eopN),
    .holdAck(holdAck), .upperWrap(upperWrap), .ctl(ctl),
    .grantOh(grantOh), .holdReq(holdReq)
  );

  dmaSeqPath #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .LOW_W(LOW_W)) uPath (
    .clk(clk), .rstN(rstN), .ctl(ctl), .grantOh(grantOh),
    .startAddr(startAddr), .polWr(polWr), .polHigh(polHigh),
    .chanAck(chanAck), .addrOut(addrOut), .upperOut(upperOut),
    .upperStb(upperStb), .upperWrap(upperWrap)
  );

  assign addrEn = ctl.busOwn;
endmodule

// File: rtl/dmaBusSeqChk.sv
module dmaBusSeqChk #(
  parameter int NUM_CH = 4,
  parameter int ADDR_W = 16,
  parameter int LOW_W  = 8
) (
  input logic                    clk,
  input logic                    rstN,
  input logic [NUM_CH-1:0]       chanReq,
  input logic [NUM_CH-1:0]       chanMask,
  input logic [NUM_CH-1:0]       softReq,
  input logic                    blockMode,
  input logic                    eopN,
  input logic [ADDR_W-1:0]       startAddr,
  input logic                    polWr,
  input logic                    polHigh,
  input logic                    holdAck,
  input logic                    holdReq,
  input logic                    addrEn,
  input logic [NUM_CH-1:0]       chanAck,
  input logic [LOW_W-1:0]        addrOut,
  input logic [ADDR_W-LOW_W-1:0] upperOut,
  input logic                    upperStb
);
  assert_hold_needs_pending_R1: assert property (@(posedge clk) disable iff (!rstN)
    $rose(holdReq) |-> $past(|((chanReq & ~chanMask) | softReq)));

  assert_bus_after_grant_R2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(addrEn) |-> $past(holdAck) && $past(holdReq));

  assert_first_cycle_strobe_R4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(addrEn) |-> upperStb);

  assert_strobe_in_service_R4: assert property (@(posedge clk) disable iff (!rstN)
    upperStb |-> addrEn);

  assert_upper_held_R5: assert property (@(posedge clk) disable iff (!rstN)
    (addrEn && $past(addrEn) && !upperStb) |-> $stable(upperOut));

  assert_release_together_R7: assert property (@(posedge clk) disable iff (!rstN)
    $fell(addrEn) |-> !holdReq);

  assert_enable_under_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    addrEn |-> holdReq);

  assert_single_ack_R9: assert property (@(posedge clk) disable iff (!rstN)
    addrEn |-> ($countones(chanAck) == 1 || $countones(~chanAck) == 1));

  assert_no_ack_idle_R9: assert property (@(posedge clk) disable iff (!rstN)
    !addrEn |-> (chanAck == '0 || chanAck == '1));
endmodule

bind dmaBusSeq dmaBusSeqChk #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .LOW_W(LOW_W)) u_chk (.*);

// File: tb/sim_dmaBusSeq.sv
module sim_dmaBusSeq;
  typedef struct {
    int         cyc;
    logic       hr;
    logic       ae;
    logic       stb;
    logic [3:0] ack;
    logic [7:0] lo;
    logic [7:0] up;
    logic       chkUp;
    string      tag;
  } expItem_t;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [3:0] chanReq = '0, chanMask = '0, softReq = '0;
  logic blockMode = 1'b0, eopN = 1'b1, polWr = 1'b0, polHigh = 1'b0, holdAck = 1'b0;
  logic [15:0] startAddr = '0;
  logic holdReq, addrEn, upperStb;
  logic [3:0] chanAck;
  logic [7:0] addrOut, upperOut;

  int cyc = 0;
  int nChecks = 0;
  int nFails = 0;
  logic benchPolHigh = 1'b0;
  bit finished = 0;
  expItem_t q[$];

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  dmaBusSeq u0 (
    .clk(clk), .rstN(rstN), .chanReq(chanReq), .chanMask(chanMask),
    .softReq(softReq), .blockMode(blockMode), .eopN(eopN),
    .startAddr(startAddr), .polWr(polWr), .polHigh(polHigh),
    .holdAck(holdAck), .holdReq(holdReq), .addrEn(addrEn),
    .chanAck(chanAck), .addrOut(addrOut), .upperOut(upperOut),
    .upperStb(upperStb)
  );

  function automatic logic [3:0] ackExp(input int ch, input logic act);
    logic [3:0] oh;
    oh = act ? (4'b0001 << ch) : 4'b0000;
    return benchPolHigh ? oh : ~oh;
  endfunction

  function automatic void push(input int c, input logic hr, input logic ae,
                               input logic stb, input int ch, input logic [15:0] a,
                               input string tag);
    expItem_t e;
    e.cyc = c; e.hr = hr; e.ae = ae; e.stb = stb;
    e.ack = ackExp(ch, ae);
    e.lo = ae ? a[7:0] : 8'h00;
    e.up = a[15:8];
    e.chkUp = ae;
    e.tag = tag;
    q.push_back(e);
  endfunction

  // monitor: compares the front item when its cycle comes up
  initial begin
    forever begin
      @(posedge clk);
      #15;
      while (q.size() > 0 && q[0].cyc <= cyc) begin
        expItem_t e;
        e = q.pop_front();
        nChecks++;
        if (e.cyc != cyc || holdReq !== e.hr || addrEn !== e.ae || upperStb !== e.stb ||
            chanAck !== e.ack || addrOut !== e.lo || (e.chkUp && upperOut !== e.up)) begin
          nFails++;
          $display("FAIL %s cyc %0d: got hr=%b ae=%b stb=%b ack=%b lo=%h up=%h exp hr=%b ae=%b stb=%b ack=%b lo=%h up=%h",
                   e.tag, cyc, holdReq, addrEn, upperStb, chanAck, addrOut, upperOut,
                   e.hr, e.ae, e.stb, e.ack, e.lo, e.up);
        end
      end
    end
  end

  task automatic direct(input string tag, input logic ok, input string got, input string exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: got %s exp %s", tag, got, exp);
    end
  endtask

  // driver: run one service and push the expected trace
  task automatic svc(input logic [3:0] req, input logic [3:0] msk, input logic [3:0] sft,
                     input logic [15:0] start, input logic blk, input int nx,
                     input int dly, input int ch, input string tag);
    int n, c, eopCyc;
    logic [15:0] a;
    @(posedge clk); #1;
    n = cyc;
    chanReq = req; chanMask = msk; softReq = sft;
    startAddr = start; blockMode = blk;
    c = n + 1;
    for (int d = 0; d <= dly; d++) begin
      push(c, 1'b1, 1'b0, 1'b0, ch, start, {tag, " wait"});
      c++;
    end
    push(c, 1'b1, 1'b1, 1'b1, ch, start, {tag, " first strobe"});
    c++;
    eopCyc = c;
    for (int k = 0; k < nx; k++) begin
      a = start + 16'(k);
      if (k > 0 && a[7:0] == 8'h00) begin
        push(c, 1'b1, 1'b1, 1'b1, ch, a, {tag, " wrap strobe"});
        c++;
      end
      push(c, 1'b1, 1'b1, 1'b0, ch, a, {tag, " xfer"});
      eopCyc = c;
      c++;
    end
    for (int t = 0; t < 3; t++) begin
      push(c + t, 1'b0, 1'b0, 1'b0, ch, 16'h0, {tag, " release"});
    end
    while (cyc < c + 3) begin
      @(posedge clk); #1;
      if (cyc == n + 1 + dly) holdAck = 1'b1;
      if (cyc == n + 2 + dly) begin
        chanReq = '0; softReq = '0;
      end
      eopN = (blk && cyc == eopCyc) ? 1'b0 : 1'b1;
      if (cyc == eopCyc + 1) holdAck = 1'b0;
    end
  endtask

  initial begin
    #(20 * 200000);
    if (!finished) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    @(posedge clk); #15;
    // R8 / R1 reset state
    direct("R8 reset ack active low", chanAck === 4'b1111, $sformatf("%b", chanAck), "1111");
    direct("R1 reset no hold", holdReq === 1'b0 && addrEn === 1'b0 && upperStb === 1'b0,
           $sformatf("%b%b%b", holdReq, addrEn, upperStb), "000");

    // R1: masked request alone is ignored
    begin
      int n;
      @(posedge clk); #1;
      n = cyc;
      chanReq = 4'b0010; chanMask = 4'b0010;
      for (int t = 1; t <= 4; t++) push(n + t, 1'b0, 1'b0, 1'b0, 0, 16'h0, "R1 masked");
      repeat (5) @(posedge clk);
      #1 chanReq = '0; chanMask = '0;
    end

    // R2 R4 R7: single transfer, acknowledge in same cycle
    svc(4'b0100, 4'b0000, 4'b0000, 16'hA35C, 1'b0, 1, 0, 2, "R2 R4 R7 single ch2");
    // R3 R2: priority with slow grant
    svc(4'b1010, 4'b0000, 4'b0000, 16'h0710, 1'b0, 1, 2, 1, "R3 R2 prio ch1");
    // R1: software request overrides mask
    svc(4'b1000, 4'b1000, 4'b1000, 16'h55AA, 1'b0, 1, 1, 3, "R1 soft ch3");
    // R3: hardware ch0 beats software ch2
    svc(4'b0001, 4'b0000, 4'b0100, 16'h2001, 1'b0, 1, 0, 0, "R3 prio ch0");
    // R5 R6 R7: block across a low-byte wrap
    svc(4'b0010, 4'b0000, 4'b0000, 16'h12FD, 1'b1, 6, 0, 1, "R5 R6 R7 block wrap");
    // R5 R6: block without wrap
    svc(4'b0100, 4'b0000, 4'b0000, 16'h3040, 1'b1, 4, 1, 2, "R5 R6 block flat");

    // R8: switch acknowledge polarity to active high
    @(posedge clk); #1;
    polWr = 1'b1; polHigh = 1'b1;
    @(posedge clk); #1;
    polWr = 1'b0; polHigh = 1'b0;
    benchPolHigh = 1'b1;
    #14;
    direct("R8 idle ack after polarity write", chanAck === 4'b0000, $sformatf("%b", chanAck), "0000");
    svc(4'b0001, 4'b0000, 4'b0000, 16'h00FF, 1'b1, 3, 0, 0, "R8 R5 active high ch0");

    repeat (3) @(posedge clk);
    #16;
    direct("R9 queue drained", q.size() == 0, $sformatf("%0d", q.size()), "0");
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule